// File: doc/BRIEF.md
# Shared-Memory Instruction Line Fetcher

This block is the fetch front end of a small 32-bit core. Code normally runs from a private 512-word register RAM, read through a one-cycle synchronous port. When the 17-bit program counter points at or above word 512, the block fetches from a large shared memory instead. It asks for a whole 4-word (128-bit) line through a request/grant port and keeps that line in a single buffer. The buffer is tagged with the line address. From it the block hands out one instruction at a time until the program counter leaves the line.

The decode stage takes each presented instruction with `instr_take`. In the same cycle it tells the block how control flow continues: sequential, a long absolute jump, a long call, a long return, the legacy local jump-with-link, or a counted or tested loop branch. A long call writes its link word to the fixed local register 0x1EF through a register-file write port, and can put the carry and zero flags into that word. A long return can load them back. Loop branches are PC-relative only while the code runs from shared memory.

Top module: `xmem_fetch`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `instr_valid` and `mem_req` are low. The first fetch is a local read of word 0 (`loc_en` high, `loc_addr` 0).
- R2: For a PC below 512, the block raises `loc_en` with `loc_addr` = PC[8:0]. It presents `loc_rdata` of the following cycle as `instr`, with `instr_pc` = PC. No shared request is made.
- R3: For a PC of 512 or above, with no valid line whose tag equals PC[16:2], the block raises `mem_req` with `mem_addr` = PC[16:2]. It holds both until `mem_gnt` is sampled high, and keeps `instr_valid` low meanwhile. On grant, `mem_rdata` is stored (word k at bits 32k+31..32k), and word PC[1:0] is presented on the next cycle.
- R4: Sequential execution inside a buffered line makes no new request. After the four words of a line are consumed, the next sequential PC causes exactly one refill.
- R5: Long call (`br_op` 2): the next PC is `br_arg[16:0]`. One cycle later `lnk_we` pulses with `lnk_addr` 0x1EF. `lnk_data[16:0]` is the call's PC+1. When `br_flags` is set, bit 17 holds `c_in` and bit 18 holds `z_in`; otherwise those bits are 0. Bits 31..19 are always 0.
- R6: Long return (`br_op` 3): the next PC is `br_arg[16:0]`. When `br_flags` is set, `flag_we` pulses one cycle later with `c_out` = `br_arg[17]` and `z_out` = `br_arg[18]`. No other operation pulses `flag_we`, and `c_out`/`z_out` then keep their values.
- R7: Long jump (`br_op` 1): the next PC is `br_arg[16:0]`, and no link write occurs.
- R8: Every taken redirect invalidates the line, so a branch to an address inside the current line still causes one refill.
- R9: Legacy local jump (`br_op` 4): the next PC is `br_arg[8:0]` (local space). One cycle later `lnk_we` pulses with `lnk_addr` = `br_dreg`, and `lnk_data` is PC+1 zero-extended.
- R10: Loop branch (`br_op` 5), taken when `br_cond` is 1. From a local PC the target is `br_arg[8:0]`. From a shared PC the target is PC+1 plus `br_arg[8:0]` read as a signed 9-bit offset. When not taken, the next PC is PC+1. Sequential (`br_op` 0) is always PC+1.
- R11: While `instr_valid` is high and `instr_take` is low, `instr_valid`, `instr` and `instr_pc` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | output | 1 | Presented instruction is valid |
| instr | output | 32 | Presented instruction word |
| instr_pc | output | 17 | Address of the presented instruction |
| instr_take | input | 1 | Decode consumes the presented instruction |
| br_op | input | 3 | Flow operation of the consumed instruction |
| br_arg | input | 19 | Target, offset or link word operand |
| br_cond | input | 1 | Loop branch condition is true |
| br_flags | input | 1 | Save or restore flags on long call or return |
| br_dreg | input | 9 | Link register for the legacy local jump |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| flag_we | output | 1 | Flags restore strobe |
| c_out | output | 1 | Restored carry flag |
| z_out | output | 1 | Restored zero flag |
| lnk_we | output | 1 | Link register write strobe |
| lnk_addr | output | 9 | Link register address |
| lnk_data | output | 32 | Link word |
| loc_en | output | 1 | Local RAM read enable |
| loc_addr | output | 9 | Local RAM read address |
| loc_rdata | input | 32 | Local RAM data, one cycle after the read |
| mem_req | output | 1 | Shared line request |
| mem_addr | output | 15 | Requested line address (PC[16:2]) |
| mem_gnt | input | 1 | Grant; `mem_rdata` valid in the same cycle |
| mem_rdata | input | 128 | Shared line data |

## Verification
The bench uses the default configuration: 17-bit PC, 512 local words and 4-word lines. That size lets it step through every local address in order and across the boundary into shared space. It then runs sixteen consecutive lines with grant delays of zero to three cycles, which exercises every in-line word offset at hit and at refill. Branch checks sweep jump targets at each offset, all four flag combinations on call and return, and signed loop offsets from -6 to +6 including a branch to itself. Every expected word and address is computed from the address arithmetic alone.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_JMPX  = 3'd1,
    OP_CALLX = 3'd2,
    OP_RETX  = 3'd3,
    OP_JMPL  = 3'd4,
    OP_LOOP  = 3'd5
  } br_op_t;

  typedef enum logic [1:0] {
    ST_ISSUE,
    ST_LWAIT,
    ST_REQ,
    ST_HOLD
  } fst_t;

endpackage

// File: rtl/xmem_line.sv
module xmem_line #(
  parameter int PC_W       = 17,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fill,
  input  logic [LINE_WORDS*WORD_W-1:0] fill_data,
  input  logic                         inval,
  input  logic [PC_W-1:0]              pc,
  output logic                         hit,
  output logic [WORD_W-1:0]            word,
  output logic [WORD_W-1:0]            fill_word
);
  localparam int OFS_W = $clog2(LINE_WORDS);
  localparam int TAG_W = PC_W - OFS_W;

  logic [WORD_W-1:0] words [LINE_WORDS];
  logic [TAG_W-1:0]  tag;
  logic              valid;

  always_ff @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < LINE_WORDS; i++) begin
        words[i] <= fill_data[i*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      tag   <= '0;
    end else if (fill) begin
      valid <= 1'b1;
      tag   <= pc[PC_W-1:OFS_W];
    end else if (inval) begin
      valid <= 1'b0;
    end
  end

  assign hit       = valid && (tag == pc[PC_W-1:OFS_W]);
  assign word      = words[pc[OFS_W-1:0]];
  assign fill_word = fill_data[pc[OFS_W-1:0]*WORD_W +: WORD_W];

endmodule

// File: rtl/xmem_nextpc.sv
module xmem_nextpc
  import xmem_pkg::*;
#(
  parameter int              PC_W      = 17,
  parameter int              LOC_W     = 9,
  parameter int              WORD_W    = 32,
  parameter int              REL_W     = 9,
  parameter logic [LOC_W-1:0] LINK_ADDR = 9'h1EF
) (
  input  logic [2:0]        op,
  input  logic [PC_W-1:0]   ipc,
  input  logic [PC_W+1:0]   arg,
  input  logic              cond,
  input  logic              flags_en,
  input  logic              c_in,
  input  logic              z_in,
  input  logic [LOC_W-1:0]  dreg,
  output logic [PC_W-1:0]   npc,
  output logic              redirect,
  output logic              lnk_we,
  output logic [LOC_W-1:0]  lnk_addr,
  output logic [WORD_W-1:0] lnk_data,
  output logic              flag_we,
  output logic              c_new,
  output logic              z_new
);
  logic [PC_W-1:0] seq, rel_ext, loc_tgt;
  logic            shared_mode;

  assign seq         = ipc + 1'b1;
  assign rel_ext     = {{(PC_W-REL_W){arg[REL_W-1]}}, arg[REL_W-1:0]};
  assign loc_tgt     = {{(PC_W-LOC_W){1'b0}}, arg[LOC_W-1:0]};
  assign shared_mode = (ipc[PC_W-1:LOC_W] != '0);

  always_comb begin
    npc      = seq;
    redirect = 1'b0;
    lnk_we   = 1'b0;
    lnk_addr = LINK_ADDR;
    lnk_data = '0;
    flag_we  = 1'b0;
    c_new    = arg[PC_W];
    z_new    = arg[PC_W+1];
    case (br_op_t'(op))
      OP_JMPX: begin
        npc      = arg[PC_W-1:0];
        redirect = 1'b1;
      end
      OP_CALLX: begin
        npc                = arg[PC_W-1:0];
        redirect           = 1'b1;
        lnk_we             = 1'b1;
        lnk_data[PC_W-1:0] = seq;
        lnk_data[PC_W]     = flags_en & c_in;
        lnk_data[PC_W+1]   = flags_en & z_in;
      end
      OP_RETX: begin
        npc      = arg[PC_W-1:0];
        redirect = 1'b1;
        flag_we  = flags_en;
      end
      OP_JMPL: begin
        npc                = loc_tgt;
        redirect           = 1'b1;
        lnk_we             = 1'b1;
        lnk_addr           = dreg;
        lnk_data[PC_W-1:0] = seq;
      end
      OP_LOOP: begin
        if (cond) begin
          npc      = shared_mode ? (seq + rel_ext) : loc_tgt;
          redirect = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/xmem_fetch.sv
module xmem_fetch
  import xmem_pkg::*;
#(
  parameter int               PC_W       = 17,
  parameter int               LOC_W      = 9,
  parameter int               WORD_W     = 32,
  parameter int               LINE_WORDS = 4,
  parameter int               REL_W      = 9,
  parameter logic [LOC_W-1:0] LINK_ADDR  = 9'h1EF,
  parameter logic [PC_W-1:0]  RESET_PC   = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic                         instr_valid,
  output logic [WORD_W-1:0]            instr,
  output logic [PC_W-1:0]              instr_pc,
  input  logic                         instr_take,
  input  logic [2:0]                   br_op,
  input  logic [PC_W+1:0]              br_arg,
  input  logic                         br_cond,
  input  logic                         br_flags,
  input  logic [LOC_W-1:0]             br_dreg,
  input  logic                         c_in,
  input  logic                         z_in,
  output logic                         flag_we,
  output logic                         c_out,
  output logic                         z_out,
  output logic                         lnk_we,
  output logic [LOC_W-1:0]             lnk_addr,
  output logic [WORD_W-1:0]            lnk_data,
  output logic                         loc_en,
  output logic [LOC_W-1:0]             loc_addr,
  input  logic [WORD_W-1:0]            loc_rdata,
  output logic                         mem_req,
  output logic [PC_W-$clog2(LINE_WORDS)-1:0] mem_addr,
  input  logic                         mem_gnt,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rdata
);
  localparam int OFS_W = $clog2(LINE_WORDS);

  fst_t              st;
  logic [PC_W-1:0]   fpc;
  logic              is_local, take, fill;
  logic              hit;
  logic [WORD_W-1:0] hit_word, fill_word;

  logic [PC_W-1:0]   n_pc;
  logic              n_redirect, n_lnk_we, n_flag_we, n_c, n_z;
  logic [LOC_W-1:0]  n_lnk_addr;
  logic [WORD_W-1:0] n_lnk_data;

  assign is_local = (fpc[PC_W-1:LOC_W] == '0);
  assign take     = (st == ST_HOLD) && instr_take;
  assign fill     = (st == ST_REQ) && mem_gnt;

  assign loc_en   = (st == ST_ISSUE) && is_local;
  assign loc_addr = fpc[LOC_W-1:0];
  assign mem_req  = (st == ST_REQ);
  assign mem_addr = fpc[PC_W-1:OFS_W];

  xmem_line #(
    .PC_W(PC_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
  ) u_line (
    .clk(clk), .rst(rst), .fill(fill), .fill_data(mem_rdata),
    .inval(take && n_redirect), .pc(fpc),
    .hit(hit), .word(hit_word), .fill_word(fill_word)
  );

  xmem_nextpc #(
    .PC_W(PC_W), .LOC_W(LOC_W), .WORD_W(WORD_W), .REL_W(REL_W),
    .LINK_ADDR(LINK_ADDR)
  ) u_npc (
    .op(br_op), .ipc(instr_pc), .arg(br_arg), .cond(br_cond),
    .flags_en(br_flags), .c_in(c_in), .z_in(z_in), .dreg(br_dreg),
    .npc(n_pc), .redirect(n_redirect), .lnk_we(n_lnk_we),
    .lnk_addr(n_lnk_addr), .lnk_data(n_lnk_data),
    .flag_we(n_flag_we), .c_new(n_c), .z_new(n_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_ISSUE;
      fpc         <= RESET_PC;
      instr_valid <= 1'b0;
      instr       <= '0;
      instr_pc    <= '0;
      lnk_we      <= 1'b0;
      lnk_addr    <= '0;
      lnk_data    <= '0;
      flag_we     <= 1'b0;
      c_out       <= 1'b0;
      z_out       <= 1'b0;
    end else begin
      lnk_we  <= 1'b0;
      flag_we <= 1'b0;
      case (st)
        ST_ISSUE: begin
          if (is_local) begin
            st <= ST_LWAIT;
          end else if (hit) begin
            instr       <= hit_word;
            instr_pc    <= fpc;
            instr_valid <= 1'b1;
            st          <= ST_HOLD;
          end else begin
            st <= ST_REQ;
          end
        end
        ST_LWAIT: begin
          instr       <= loc_rdata;
          instr_pc    <= fpc;
          instr_valid <= 1'b1;
          st          <= ST_HOLD;
        end
        ST_REQ: begin
          if (mem_gnt) begin
            instr       <= fill_word;
            instr_pc    <= fpc;
            instr_valid <= 1'b1;
            st          <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (instr_take) begin
            instr_valid <= 1'b0;
            fpc         <= n_pc;
            st          <= ST_ISSUE;
            lnk_we      <= n_lnk_we;
            flag_we     <= n_flag_we;
            if (n_lnk_we) begin
              lnk_addr <= n_lnk_addr;
              lnk_data <= n_lnk_data;
            end
            if (n_flag_we) begin
              c_out <= n_c;
              z_out <= n_z;
            end
          end
        end
        default: st <= ST_ISSUE;
      endcase
    end
  end

endmodule

// File: rtl/xmem_fetch_chk.sv
module xmem_fetch_chk
  import xmem_pkg::*;
#(
  parameter int               PC_W       = 17,
  parameter int               LOC_W      = 9,
  parameter int               WORD_W     = 32,
  parameter int               LINE_WORDS = 4,
  parameter logic [LOC_W-1:0] LINK_ADDR  = 9'h1EF
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              instr_valid,
  input logic [WORD_W-1:0]                 instr,
  input logic [PC_W-1:0]                   instr_pc,
  input logic                              instr_take,
  input logic [2:0]                        br_op,
  input logic                              br_flags,
  input logic                              flag_we,
  input logic                              lnk_we,
  input logic [LOC_W-1:0]                  lnk_addr,
  input logic [WORD_W-1:0]                 lnk_data,
  input logic                              mem_req,
  input logic [PC_W-$clog2(LINE_WORDS)-1:0] mem_addr,
  input logic                              mem_gnt
);
  localparam int OFS_W = $clog2(LINE_WORDS);
  localparam int TAG_W = PC_W - OFS_W;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!instr_valid && !mem_req)); // R1

  AST_REQ_SHARED_ONLY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[TAG_W-1:LOC_W-OFS_W] != '0)); // R3

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R3

  AST_NO_INSTR_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !instr_valid); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !instr_take) |=>
      (instr_valid && $stable(instr) && $stable(instr_pc))); // R11

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_take && br_op == OP_CALLX) |=>
      (lnk_we && lnk_addr == LINK_ADDR &&
       lnk_data[PC_W-1:0] == $past(instr_pc) + 1'b1)); // R5

  AST_FLAGS_RET_ONLY: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_take && !(br_op == OP_RETX && br_flags)) |=> !flag_we); // R6

  AST_JMPX_NO_LINK: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_take && br_op == OP_JMPX) |=> !lnk_we); // R7

endmodule

bind xmem_fetch xmem_fetch_chk #(
  .PC_W(PC_W), .LOC_W(LOC_W), .WORD_W(WORD_W),
  .LINE_WORDS(LINE_WORDS), .LINK_ADDR(LINK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
  .instr_pc(instr_pc), .instr_take(instr_take), .br_op(br_op),
  .br_flags(br_flags), .flag_we(flag_we), .lnk_we(lnk_we),
  .lnk_addr(lnk_addr), .lnk_data(lnk_data), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_gnt(mem_gnt)
);

// File: tb/sim_xmem_fetch.sv
module sim_xmem_fetch;
  import xmem_pkg::*;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instr_valid;
  logic [31:0]  instr;
  logic [16:0]  instr_pc;
  logic         instr_take = 1'b0;
  logic [2:0]   br_op = 3'd0;
  logic [18:0]  br_arg = '0;
  logic         br_cond = 1'b0;
  logic         br_flags = 1'b0;
  logic [8:0]   br_dreg = '0;
  logic         c_in = 1'b0;
  logic         z_in = 1'b0;
  logic         flag_we, c_out, z_out;
  logic         lnk_we;
  logic [8:0]   lnk_addr;
  logic [31:0]  lnk_data;
  logic         loc_en;
  logic [8:0]   loc_addr;
  logic [31:0]  loc_rdata = '0;
  logic         mem_req;
  logic [14:0]  mem_addr;
  logic         mem_gnt = 1'b0;
  logic [127:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int grants = 0;
  int gnt_delay = 0;
  int gnt_wait = 0;

  always #5 clk = ~clk;

  xmem_fetch u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .instr_pc(instr_pc), .instr_take(instr_take), .br_op(br_op),
    .br_arg(br_arg), .br_cond(br_cond), .br_flags(br_flags),
    .br_dreg(br_dreg), .c_in(c_in), .z_in(z_in), .flag_we(flag_we),
    .c_out(c_out), .z_out(z_out), .lnk_we(lnk_we), .lnk_addr(lnk_addr),
    .lnk_data(lnk_data), .loc_en(loc_en), .loc_addr(loc_addr),
    .loc_rdata(loc_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] loc_word(input logic [8:0] a);
    return 32'h4C00_0000 | {23'd0, a};
  endfunction

  function automatic logic [31:0] sh_word(input logic [16:0] a);
    return 32'hC000_0000 ^ ({15'd0, a} * 32'h0000_9E37);
  endfunction

  function automatic logic [127:0] sh_line(input logic [14:0] la);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[k*32 +: 32] = sh_word({la, 2'(k)});
    return v;
  endfunction

  // local RAM model: synchronous read, one cycle of latency
  always @(posedge clk) if (loc_en) loc_rdata <= loc_word(loc_addr);

  // shared memory responder, grant after gnt_delay waiting cycles
  always @(negedge clk) begin
    if (mem_req && !mem_gnt && gnt_wait >= gnt_delay) begin
      mem_gnt   = 1'b1;
      mem_rdata = sh_line(mem_addr);
      grants++;
      gnt_wait  = 0;
    end else begin
      mem_gnt = 1'b0;
      if (mem_req) gnt_wait++; else gnt_wait = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic expect_instr(input logic [16:0] pc, input logic [31:0] w, input string tag);
    int n = 0;
    bit seen = 0;
    while (!instr_valid && n < 40) begin
      @(negedge clk);
      n++;
      if (mem_req && !seen) begin
        seen = 1;
        check(mem_addr == pc[16:2] && !instr_valid && pc >= 17'd512, "R3 request",
              {48'd0, 1'b0, mem_addr}, {49'd0, pc[16:2]});
      end
    end
    check(instr_valid && instr_pc == pc && instr == w, tag,
          {15'd0, instr_valid, instr_pc, instr}, {15'd0, 1'b1, pc, w});
  endtask

  task automatic take(input logic [2:0] op, input logic [18:0] arg,
                      input logic cond, input logic fl, input logic [8:0] dreg);
    br_op = op; br_arg = arg; br_cond = cond; br_flags = fl; br_dreg = dreg;
    instr_take = 1'b1;
    @(negedge clk);
    instr_take = 1'b0;
    br_op = OP_SEQ; br_arg = '0; br_cond = 1'b0; br_flags = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R4 act %0d exp %0d", 0, 1);
    summary();
  end

  initial begin
    logic [16:0] p, t;
    logic [31:0] w0;
    int g;
    repeat (3) @(negedge clk);
    check(!instr_valid && !mem_req, "R1 reset outputs", {62'd0, instr_valid, mem_req}, 64'd0);
    rst = 1'b0;
    check(!instr_valid && !mem_req && loc_en && loc_addr == 9'd0, "R1 first fetch",
          {53'd0, instr_valid, mem_req, loc_en, loc_addr}, {55'd0, 1'b1, 9'd0});

    // R2: every local address in order
    for (int a = 0; a < 512; a++) begin
      expect_instr(17'(a), loc_word(9'(a)), "R2 local word");
      take(OP_SEQ, '0, 0, 0, '0);
    end
    check(grants == 0, "R2 no shared request", 64'(grants), 64'd0);

    // R3 / R4: sixteen sequential lines, varying grant latency
    g = grants;
    for (int l = 0; l < 16; l++) begin
      gnt_delay = l % 4;
      for (int k = 0; k < 4; k++) begin
        p = 17'(512 + 4*l + k);
        expect_instr(p, sh_word(p), k == 0 ? "R3 refill word" : "R4 hit word");
        check(grants == g + l + 1, "R4 one refill per line", 64'(grants), 64'(g + l + 1));
        take(OP_SEQ, '0, 0, 0, '0);
      end
    end
    gnt_delay = 1;

    // R11: hold while not taken
    p = 17'd576;
    expect_instr(p, sh_word(p), "R3 next line");
    w0 = instr;
    repeat (3) @(negedge clk);
    check(instr_valid && instr == w0 && instr_pc == p, "R11 hold",
          {15'd0, instr_valid, instr_pc, instr}, {15'd0, 1'b1, p, w0});

    // R7 / R8: long jumps to each word offset, then to itself
    for (int k = 0; k < 4; k++) begin
      t = 17'h10000 + 17'(8*k + k);
      take(OP_JMPX, {2'b11, t}, 0, 0, '0);
      check(!lnk_we && !flag_we, "R7 no link on jump", {62'd0, lnk_we, flag_we}, 64'd0);
      g = grants;
      expect_instr(t, sh_word(t), "R7 jump target");
      check(grants == g + 1, "R8 refill after jump", 64'(grants), 64'(g + 1));
      g = grants;
      take(OP_JMPX, {2'b00, t}, 0, 0, '0);
      expect_instr(t, sh_word(t), "R8 self jump");
      check(grants == g + 1, "R8 same-line branch refills", 64'(grants), 64'(g + 1));
      p = t;
    end

    // R5 / R6: calls and returns over every flag combination
    for (int f = 0; f < 5; f++) begin
      logic fe, cc, zz;
      logic [31:0] ld;
      fe = (f < 4); cc = f[0]; zz = f[1];
      c_in = cc; z_in = zz;
      t = (f == 4) ? 17'h00010 : 17'h18000 + 17'(16*f + f);
      take(OP_CALLX, {2'b00, t}, 0, fe, '0);
      ld = {13'd0, fe & zz, fe & cc, p + 17'd1};
      check(lnk_we && lnk_addr == 9'h1EF && lnk_data == ld, "R5 call link",
            {22'd0, lnk_we, lnk_addr, lnk_data}, {22'd0, 1'b1, 9'h1EF, ld});
      check(!flag_we, "R6 no flag strobe on call", {63'd0, flag_we}, 64'd0);
      expect_instr(t, (f == 4) ? loc_word(t[8:0]) : sh_word(t), "R5 call target");
      c_in = ~cc; z_in = ~zz;
      take(OP_RETX, ld[18:0], 0, fe, '0);
      if (fe)
        check(flag_we && c_out == cc && z_out == zz, "R6 flags restored",
              {61'd0, flag_we, c_out, z_out}, {61'd0, 1'b1, cc, zz});
      else
        check(!flag_we, "R6 no restore", {63'd0, flag_we}, 64'd0);
      check(!lnk_we, "R6 no link on return", {63'd0, lnk_we}, 64'd0);
      p = p + 17'd1;
      expect_instr(p, sh_word(p), "R6 return target");
    end

    // R9: legacy local jump with link from shared space
    take(OP_JMPL, 19'h7FC40, 0, 0, 9'h0A3);
    check(lnk_we && lnk_addr == 9'h0A3 && lnk_data == {15'd0, p + 17'd1}, "R9 legacy link",
          {22'd0, lnk_we, lnk_addr, lnk_data}, {22'd0, 1'b1, 9'h0A3, 15'd0, p + 17'd1});
    expect_instr(17'h00040, loc_word(9'h040), "R9 local target");

    // R10: loop branches in local space
    take(OP_LOOP, 19'h7FF23, 1, 0, '0);
    expect_instr(17'h00123, loc_word(9'h123), "R10 local taken");
    take(OP_LOOP, 19'h00050, 0, 0, '0);
    expect_instr(17'h00124, loc_word(9'h124), "R10 local not taken");

    // R10: relative loop branches in shared space
    p = 17'h14000;
    take(OP_JMPX, {2'b00, p}, 0, 0, '0);
    expect_instr(p, sh_word(p), "R7 jump to loop base");
    for (int o = -6; o <= 6; o++) begin
      logic [8:0] off;
      off = 9'(o);
      t = p + 17'd1 + {{8{off[8]}}, off};
      g = grants;
      take(OP_LOOP, {10'h3FF, off}, 1, 0, '0);
      expect_instr(t, sh_word(t), "R10 shared relative taken");
      if (o == -1)
        check(grants == g + 1, "R8 self loop refills", 64'(grants), 64'(g + 1));
      p = t;
      take(OP_LOOP, 19'h00010, 0, 0, '0);
      p = p + 17'd1;
      expect_instr(p, sh_word(p), "R10 shared not taken");
    end

    summary();
  end

endmodule